// File: doc/BRIEF.md
# In-System Loadable ROM Emulator

This block stands in for a read-only program memory with a writable byte array that a host can reload while the target system stays plugged in and powered. The host has an 8-bit data bus and three handshake lines. For each byte it wants to store, it clocks three bytes into a three-stage byte shift chain. The first byte is the address high byte, the second is the address low byte and the last is the data byte. The host then raises a separate commit line, and the byte held in the chain is written to the array.

An ownership line chooses who uses the array. In load mode the shift chain supplies the write address and data, and the target-side read port is idle. In run mode the target reads through its own active-low chip-enable and output-enable. Its address is cut down to the selected emulated ROM size, so reads above that size alias onto the lower image.

A write-protect input blocks every write. The array's chip enable is deasserted (standby) whenever no write and no target read is taking place. A pair of reset outputs, one active-high and one active-low, holds the target in reset while the loader owns the memory. All host lines are asynchronous. Each passes through a two-flop synchroniser and acts on its rising edge. The default array depth is 4 KiB (ADDR_W = 12). Setting ADDR_W to 16 gives the full 64 KiB image.

Top module: `rom_emu_top`

## Requirements
- R1: A commit in load mode writes the third byte of the packet to the address whose high byte is the first packet byte and whose low byte is the second. Only the low ADDR_W bits of that 16-bit address are used.
- R2: Each rising edge of hostStrobe in load mode shifts hostData into the chain exactly once. A packet longer than three bytes keeps only its last three bytes.
- R3: Each rising edge of hostSelect performs at most one array write, however long the line stays high.
- R4: With hostInit = 1 (load mode), tgtDataEn is 0. With hostInit = 0 (run mode), tgtDataEn is 1 exactly when tgtCeN and tgtOeN are both 0, and tgtData is 0 whenever tgtDataEn is 0. In run mode, hostStrobe and hostSelect pulses change neither the chain nor the array.
- R5: While writeProtect = 1, no array write takes place.
- R6: In run mode the target address is ANDed with a mask of (ADDR_W − n) low ones, where n is the number of bits of sizeSel that are 1 (0 → full size, 1 → half, 2 → quarter, 3 → eighth).
- R7: ramCeN is 0 only in a cycle that performs an array write or an active target read, and is 1 otherwise.
- R8: loaderActive is 1 in load mode. In load mode tgtReset is 1 and tgtResetN is 0, and both are inverted in run mode.
- R9: After reset the block is in run mode with an empty chain, no write pending, ramCeN = 1 and tgtDataEn = 0 while the target is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostData | input | 8 | Host byte bus feeding the shift chain |
| hostStrobe | input | 1 | Host shift strobe, asynchronous, acts on rising edge |
| hostSelect | input | 1 | Host commit line, asynchronous, acts on rising edge |
| hostInit | input | 1 | Ownership: 1 = load mode, 0 = run mode |
| writeProtect | input | 1 | 1 blocks all array writes |
| sizeSel | input | 3 | Emulated size; each 1 bit halves the size |
| tgtAddr | input | ADDR_W | Target read address |
| tgtCeN | input | 1 | Target chip enable, active low |
| tgtOeN | input | 1 | Target output enable, active low |
| tgtData | output | 8 | Read data towards the target bus |
| tgtDataEn | output | 1 | Drive enable for the target data buffers |
| ramCeN | output | 1 | Array chip enable, active low (1 = standby) |
| loaderActive | output | 1 | Load mode indicator |
| tgtReset | output | 1 | Active-high target reset |
| tgtResetN | output | 1 | Active-low target reset |

## Verification
On every cycle the assertions check that one host pulse gives at most one shift and one write, that a shift lands the host byte in the newest stage, and that a commit stores the newest stage at the packed address. They also check that the target drive only happens in run mode with both selects low, that protection keeps the array in standby outside reads, and that the two reset outputs stay complementary. Address aliasing for each size code, the loss of an extra leading byte, and the array staying unchanged after run-mode host pulses depend on stored contents, so only the bench's read-back scenarios can show them.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAIN_DEPTH = 3;
  localparam int HOST_ADDR_W = 2 * BYTE_W;

  typedef struct packed {
    logic loadMode;
    logic shiftEn;
    logic memWr;
  } emuCtrl_t;
endpackage

// File: rtl/rom_emu_sync.sv
module rom_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipeQ <= '0;
    else       pipeQ <= {pipeQ[STAGES-2:0], din};
  end

  assign dout = pipeQ[STAGES-1];
endmodule

// File: rtl/rom_emu_ctrl.sv
module rom_emu_ctrl
  import rom_emu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostStrobe,
  input  logic     hostSelect,
  input  logic     hostInit,
  input  logic     writeProtect,
  output emuCtrl_t ctrl
);
  localparam int LINES = 3;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic strbPrev, selPrev;
  logic strbRise, selRise;

  assign rawLines = {hostInit, hostSelect, hostStrobe};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    rom_emu_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLines[g]),
      .dout(syncLines[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbPrev <= 1'b0;
      selPrev  <= 1'b0;
    end else begin
      strbPrev <= syncLines[0];
      selPrev  <= syncLines[1];
    end
  end

  assign strbRise = syncLines[0] & ~strbPrev;
  assign selRise  = syncLines[1] & ~selPrev;

  always_comb begin
    ctrl.loadMode = syncLines[2];
    ctrl.shiftEn  = strbRise & syncLines[2];
    ctrl.memWr    = selRise & syncLines[2] & ~writeProtect;
  end

  // R2: one strobe pulse gives one shift
  assert_single_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> !ctrl.shiftEn);
  // R3: one commit pulse gives one write
  assert_single_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memWr |=> !ctrl.memWr);
endmodule

// File: rtl/rom_emu_datapath.sv
module rom_emu_datapath
  import rom_emu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  emuCtrl_t          ctrl,
  input  logic [BYTE_W-1:0] hostData,
  input  logic [2:0]        sizeSel,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              tgtCeN,
  input  logic              tgtOeN,
  output logic [BYTE_W-1:0] tgtData,
  output logic              tgtDataEn,
  output logic              ramCeN
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CHAIN_DEPTH-1:0][BYTE_W-1:0] stageQ;
  logic [BYTE_W-1:0] memArr [DEPTH];
  logic [HOST_ADDR_W-1:0] packedAddr;
  logic [ADDR_W-1:0] wrAddr, rdAddr, sizeMask;
  logic [1:0] closedCnt;
  logic readAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else if (ctrl.shiftEn) begin
      stageQ[0] <= hostData;
      for (int i = 1; i < CHAIN_DEPTH; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign packedAddr = {stageQ[2], stageQ[1]};
  assign wrAddr = ADDR_W'(packedAddr);

  always_ff @(posedge clk) begin
    if (ctrl.memWr) memArr[wrAddr] <= stageQ[0];
  end

  always_comb begin
    closedCnt = '0;
    for (int i = 0; i < 3; i++) closedCnt = closedCnt + 2'(sizeSel[i]);
    sizeMask = {ADDR_W{1'b1}} >> closedCnt;
  end

  assign rdAddr    = tgtAddr & sizeMask;
  assign readAct   = ~ctrl.loadMode & ~tgtCeN & ~tgtOeN;
  assign tgtDataEn = readAct;
  assign tgtData   = readAct ? memArr[rdAddr] : '0;
  assign ramCeN    = ~(ctrl.memWr | readAct);

  // R2: a shift puts the host byte into the newest stage and ages the rest
  assert_shift_content_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> (stageQ[0] == $past(hostData)) && (stageQ[1] == $past(stageQ[0]))
                     && (stageQ[2] == $past(stageQ[1])));
  // R1: a commit stores the newest stage at the packed address
  assert_commit_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memWr |=> memArr[$past(wrAddr)] == $past(stageQ[0]));
  // R2: with no strobe, the chain holds
  assert_chain_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> $stable(stageQ));
endmodule

// File: rtl/rom_emu_top.sv
module rom_emu_top
  import rom_emu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        hostData,
  input  logic              hostStrobe,
  input  logic              hostSelect,
  input  logic              hostInit,
  input  logic              writeProtect,
  input  logic [2:0]        sizeSel,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              tgtCeN,
  input  logic              tgtOeN,
  output logic [7:0]        tgtData,
  output logic              tgtDataEn,
  output logic              ramCeN,
  output logic              loaderActive,
  output logic              tgtReset,
  output logic              tgtResetN
);
  emuCtrl_t ctrl;

  rom_emu_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostStrobe  (hostStrobe),
    .hostSelect  (hostSelect),
    .hostInit    (hostInit),
    .writeProtect(writeProtect),
    .ctrl        (ctrl)
  );

  rom_emu_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .hostData (hostData),
    .sizeSel  (sizeSel),
    .tgtAddr  (tgtAddr),
    .tgtCeN   (tgtCeN),
    .tgtOeN   (tgtOeN),
    .tgtData  (tgtData),
    .tgtDataEn(tgtDataEn),
    .ramCeN   (ramCeN)
  );

  assign loaderActive = ctrl.loadMode;
  assign tgtReset     = ctrl.loadMode;
  assign tgtResetN    = ~ctrl.loadMode;

  // R4: target drive only in run mode with both selects low
  assert_drive_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    tgtDataEn |-> (!loaderActive && !tgtCeN && !tgtOeN));
  // R5: protection keeps the array idle apart from reads
  assert_protect_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (writeProtect && !tgtDataEn) |-> ramCeN);
  // R7: in run mode with no read the array is in standby
  assert_standby_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loaderActive && !tgtDataEn) |-> ramCeN);
  // R8: the reset pair is always complementary
  assert_reset_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    tgtReset != tgtResetN);
endmodule

// File: tb/test_rom_emu_top.sv
module test_rom_emu_top;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hostData = '0;
  logic hostStrobe = 1'b0, hostSelect = 1'b0, hostInit = 1'b0, writeProtect = 1'b0;
  logic [2:0] sizeSel = '0;
  logic [AW-1:0] tgtAddr = '0;
  logic tgtCeN = 1'b1, tgtOeN = 1'b1;
  logic [7:0] tgtData;
  logic tgtDataEn, ramCeN, loaderActive, tgtReset, tgtResetN;

  int total = 0;
  int bad = 0;
  int wrSeen = 0;
  bit running = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rom_emu_top #(.ADDR_W(AW)) i_rom_emu_top (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostStrobe(hostStrobe),
    .hostSelect(hostSelect), .hostInit(hostInit), .writeProtect(writeProtect),
    .sizeSel(sizeSel), .tgtAddr(tgtAddr), .tgtCeN(tgtCeN), .tgtOeN(tgtOeN),
    .tgtData(tgtData), .tgtDataEn(tgtDataEn), .ramCeN(ramCeN),
    .loaderActive(loaderActive), .tgtReset(tgtReset), .tgtResetN(tgtResetN)
  );

  // behavioural reference: input histories, byte queue and sparse memory
  bit sH[4], gH[4], iH[4];
  byte unsigned chainQ[$] = '{8'h00, 8'h00, 8'h00};
  byte unsigned modelMem[int];

  always @(posedge clk) begin
    for (int k = 3; k > 0; k--) begin
      sH[k] = sH[k-1]; gH[k] = gH[k-1]; iH[k] = iH[k-1];
    end
    sH[0] = rstN && hostStrobe;
    gH[0] = rstN && hostSelect;
    iH[0] = rstN && hostInit;
    if (!rstN) begin
      sH = '{0, 0, 0, 0}; gH = '{0, 0, 0, 0}; iH = '{0, 0, 0, 0};
      chainQ = '{8'h00, 8'h00, 8'h00};
    end else begin
      if (gH[2] && !gH[3] && iH[2] && !writeProtect)
        modelMem[((int'(chainQ[0]) << 8) | int'(chainQ[1])) % (1 << AW)] = chainQ[2];
      if (sH[2] && !sH[3] && iH[2]) begin
        chainQ.push_back(hostData);
        void'(chainQ.pop_front());
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      bit expLoad, expEn, expWr;
      int ma, nClosed;
      expLoad = iH[1];
      expEn = !expLoad && !tgtCeN && !tgtOeN;
      expWr = gH[1] && !gH[2] && expLoad && !writeProtect;
      nClosed = int'(sizeSel[0]) + int'(sizeSel[1]) + int'(sizeSel[2]);
      ma = int'(tgtAddr) & ((1 << (AW - nClosed)) - 1);
      check("R8 loaderActive", loaderActive, expLoad);
      check("R8 tgtReset", tgtReset, expLoad);
      check("R8 tgtResetN", tgtResetN, !expLoad);
      check("R4 tgtDataEn", tgtDataEn, expEn);
      check("R7 ramCeN", ramCeN, !(expEn || expWr));
      if (!expEn) check("R4 idle data", tgtData, 0);
      else if (modelMem.exists(ma)) check("R1 read data", tgtData, modelMem[ma]);
      if (!ramCeN && !tgtDataEn) wrSeen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sendByte(byte unsigned b);
    hostData = b;
    hostStrobe = 1'b1;
    tick(4);
    hostStrobe = 1'b0;
    tick(4);
  endtask

  task automatic commit(int holdCycles);
    hostSelect = 1'b1;
    tick(holdCycles);
    hostSelect = 1'b0;
    tick(4);
  endtask

  task automatic loadByte(int addr, byte unsigned d);
    sendByte(byte'(addr >> 8));
    sendByte(byte'(addr));
    sendByte(d);
    commit(4);
  endtask

  task automatic readAt(string tag, int addr, int exp);
    tgtAddr = AW'(addr);
    tgtCeN = 1'b0;
    tgtOeN = 1'b0;
    @(negedge clk);
    check(tag, tgtData, exp);
    check(tag, tgtDataEn, 1);
    #1;
    tgtCeN = 1'b1;
    tgtOeN = 1'b1;
  endtask

  task automatic setMode(bit load);
    hostInit = load;
    tick(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    running = 1;
    // R9: reset state
    check("R9 reset loaderActive", loaderActive, 0);
    check("R9 reset ramCeN", ramCeN, 1);
    check("R9 reset tgtDataEn", tgtDataEn, 0);
    check("R9 reset tgtResetN", tgtResetN, 1);

    setMode(1);
    check("R8 load indicator", loaderActive, 1);
    loadByte(16'h0010, 8'hA5);
    loadByte(16'h0123, 8'h3C);
    loadByte(16'h1234, 8'h77);  // R1: high address bits beyond ADDR_W dropped
    // R2: four-byte packet keeps only the last three
    sendByte(8'hEE);
    loadByte(16'h0020, 8'h5A);
    // R4: target selects ignored in load mode
    tgtCeN = 1'b0; tgtOeN = 1'b0;
    tick(2);
    check("R4 load mode no drive", tgtDataEn, 0);
    tgtCeN = 1'b1; tgtOeN = 1'b1;
    // R5: protected write
    writeProtect = 1'b1;
    loadByte(16'h0010, 8'hFF);
    writeProtect = 1'b0;
    loadByte(16'h0345, 8'h99);
    // R3: held commit line writes once
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h42);
    wrSeen = 0;
    commit(30);
    check("R3 single write on held select", wrSeen, 1);

    setMode(0);
    readAt("R1 read 0x010", 'h010, 'hA5);
    readAt("R1 read 0x123", 'h123, 'h3C);
    readAt("R1 read truncated 0x234", 'h234, 'h77);
    readAt("R2 extra byte dropped", 'h020, 'h5A);
    readAt("R5 protected location kept", 'h010, 'hA5);
    readAt("R3 held write 0x100", 'h100, 'h42);
    // R4: partial selects
    tgtAddr = AW'('h010); tgtCeN = 1'b0; tgtOeN = 1'b1;
    tick(1);
    check("R4 oe high no drive", tgtDataEn, 0);
    tgtCeN = 1'b1; tgtOeN = 1'b0;
    tick(1);
    check("R4 ce high no drive", tgtDataEn, 0);
    tgtOeN = 1'b1;
    // R4: host pulses in run mode have no effect
    sendByte(8'h00); sendByte(8'h10); sendByte(8'h11);
    commit(4);
    readAt("R4 run-mode commit ignored", 'h010, 'hA5);
    // R6: size masking and aliasing
    sizeSel = 3'b111;
    readAt("R6 eighth alias", 'h210, 'hA5);
    sizeSel = 3'b011;
    readAt("R6 quarter alias", 'h410, 'hA5);
    readAt("R6 quarter alias 2", 'h523, 'h3C);
    sizeSel = 3'b100;
    readAt("R6 half alias", 'hA34, 'h77);
    sizeSel = 3'b000;
    readAt("R6 full size", 'h234, 'h77);
    // chain unchanged by run-mode strobes: recommit rewrites 0x100
    setMode(1);
    commit(4);
    setMode(0);
    readAt("R4 chain untouched in run mode", 'h100, 'h42);
    readAt("R4 location kept", 'h010, 'hA5);
    check("R8 run reset released", tgtReset, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule